// File: doc/BRIEF.md
# Integer ALU Instruction Executor

This block runs one 32-bit integer arithmetic or logical instruction per clock. It holds a 32-entry, 32-bit register file. The instruction word is split into fixed bit fields, and either a three-register form or a register-plus-constant form is decoded from it. Two source values are read combinationally, the result is computed, and it is written into the register file on the next rising clock edge.

A host core or a test harness presents an instruction word together with a valid strobe, one word per cycle. Any register can be read back through a separate debug read port. An instruction word that is not recognised raises a flag during the cycle it is presented and changes nothing.

Top module: `alu_exec_core`

## Requirements
- R1: While rst_ni is low, every register is cleared to zero, and the debug port reads zero for all 32 addresses.
- R2: When bits [31:26] are 000000 and bits [5:0] are 100000, the register named by bits [15:11] gets the sum of the registers named by bits [25:21] and [20:16]. The sum wraps modulo 2^32.
- R3: With the same fields as R2 but bits [5:0] equal to 100010, the destination gets the value from [25:21] minus the value from [20:16]. The difference wraps modulo 2^32.
- R4: When bits [31:26] are 000000 and bits [5:0] are 000000, the register named by [20:16] is shifted left by bits [10:6]. When bits [5:0] are 000010, it is shifted right by the same amount. Vacated bits are filled with zero, and bits [25:21] have no effect on the result.
- R5: When bits [31:26] are 000000, bits [5:0] select a bitwise operation on the two source registers, and the result goes to the register named by [15:11]. The codes are 100100 for AND, 100101 for OR, 100110 for XOR and 100111 for NOR.
- R6: When bits [31:26] are 001000, the register named by [20:16] gets the register named by [25:21] plus bits [15:0] sign-extended to 32 bits.
- R7: Bits [31:26] equal to 001100, 001101 and 001110 write the register named by [20:16] with the AND, OR and XOR, respectively, of the register named by [25:21] and bits [15:0] zero-extended to 32 bits.
- R8: Register 0 always reads as zero, both as a source operand and on the debug port. Any write directed to register 0 is discarded.
- R9: Any other value of bits [31:26], or any other value of bits [5:0] when bits [31:26] are 000000, drives illegal_o high during the cycle the word is valid, and no register is written.
- R10: While valid_i is low, no register is written and illegal_o stays low, whatever the instruction word is.
- R11: A result is visible on the debug port in the cycle after the instruction is presented, that is, right after the clock edge that accepts the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| dbg_addr_i | input | 5 | Register index for debug read |
| dbg_data_o | output | 32 | Debug read data, combinational |
| illegal_o | output | 1 | Unrecognised instruction, same cycle as valid_i |

## Verification
The illegal flag is combinational: the bench samples it 1 ns after it drives the instruction word at a falling edge, before the accepting rising edge. A register result is due one clock later. The bench therefore reads the destination through the debug port only after the following falling edge, once the write edge has passed. A bench-side register model is updated at that same point, so each expected value reflects every earlier write and no later one.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_ANDI  = 6'b001100;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_XORI  = 6'b001110;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_NOR = 6'b100111;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SRL, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR
  } alu_op_e;
endpackage

// File: rtl/alu_decoder.sv
module alu_decoder
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instr_i,
  output logic              legal_o,
  output alu_op_e           op_o,
  output logic [4:0]        rs_o,
  output logic [4:0]        rt_o,
  output logic [4:0]        dst_o,
  output logic [4:0]        shamt_o,
  output logic              use_imm_o,
  output logic [DATA_W-1:0] imm_o
);
  localparam int EXT_W = DATA_W - 16;

  logic [5:0]  opc, fn;
  logic [15:0] imm16;

  assign opc     = instr_i[31:26];
  assign fn      = instr_i[5:0];
  assign imm16   = instr_i[15:0];
  assign rs_o    = instr_i[25:21];
  assign rt_o    = instr_i[20:16];
  assign shamt_o = instr_i[10:6];

  always_comb begin
    legal_o   = 1'b1;
    op_o      = ALU_ADD;
    use_imm_o = 1'b1;
    dst_o     = instr_i[20:16];
    imm_o     = {{EXT_W{1'b0}}, imm16};
    unique case (opc)
      OPC_RTYPE: begin
        use_imm_o = 1'b0;
        dst_o     = instr_i[15:11];
        case (fn)
          FN_ADD:  op_o = ALU_ADD;
          FN_SUB:  op_o = ALU_SUB;
          FN_SLL:  op_o = ALU_SLL;
          FN_SRL:  op_o = ALU_SRL;
          FN_AND:  op_o = ALU_AND;
          FN_OR:   op_o = ALU_OR;
          FN_XOR:  op_o = ALU_XOR;
          FN_NOR:  op_o = ALU_NOR;
          default: legal_o = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        op_o  = ALU_ADD;
        imm_o = {{EXT_W{imm16[15]}}, imm16};  // only addi sign-extends
      end
      OPC_ANDI: op_o = ALU_AND;
      OPC_ORI:  op_o = ALU_OR;
      OPC_XORI: op_o = ALU_XOR;
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_SRL: y_o = b_i >> shamt_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_regfile.sv
module alu_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  parameter int ADDR_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic [ADDR_W-1:0] raddr_d_i,
  output logic [DATA_W-1:0] rdata_d_o
);
  logic [DATA_W-1:0] regs_q [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  regs_q[i] <= '0;
        else if (we_i && waddr_i == ADDR_W'(i))       regs_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign rdata_d_o = regs_q[raddr_d_i];
endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [4:0]        dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic              illegal_o
);
  localparam int ADDR_W = $clog2(REG_N);
  localparam int SH_W   = $clog2(DATA_W);

  logic              legal, use_imm, wr_en;
  alu_op_e           op;
  logic [4:0]        rs, rt, dst, shamt;
  logic [DATA_W-1:0] imm, rs_val, rt_val, opnd_b, result;

  alu_decoder #(.DATA_W(DATA_W)) u_dec (
    .instr_i  (instr_i),
    .legal_o  (legal),
    .op_o     (op),
    .rs_o     (rs),
    .rt_o     (rt),
    .dst_o    (dst),
    .shamt_o  (shamt),
    .use_imm_o(use_imm),
    .imm_o    (imm)
  );

  alu_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .ADDR_W(ADDR_W)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .waddr_i  (ADDR_W'(dst)),
    .wdata_i  (result),
    .raddr_a_i(ADDR_W'(rs)),
    .rdata_a_o(rs_val),
    .raddr_b_i(ADDR_W'(rt)),
    .rdata_b_o(rt_val),
    .raddr_d_i(ADDR_W'(dbg_addr_i)),
    .rdata_d_o(dbg_data_o)
  );

  assign opnd_b = use_imm ? imm : rt_val;

  alu_unit #(.DATA_W(DATA_W), .SH_W(SH_W)) u_alu (
    .op_i   (op),
    .a_i    (rs_val),
    .b_i    (opnd_b),
    .shamt_i(SH_W'(shamt)),
    .y_o    (result)
  );

  assign wr_en     = valid_i && legal && (dst != 5'd0);
  assign illegal_o = valid_i && !legal;
endmodule

// File: rtl/alu_exec_checker.sv
module alu_exec_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              illegal_o,
  input logic [4:0]        dbg_addr_i,
  input logic [DATA_W-1:0] dbg_data_o,
  input logic              wr_en,
  input logic [4:0]        wr_addr
);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!illegal_o && !wr_en));

  p_illegal_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en);

  p_zero_write_dropped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_addr != 5'd0));

  p_zero_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_addr_i == 5'd0) |-> (dbg_data_o == '0));

  p_hold_without_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ((dbg_addr_i != $past(dbg_addr_i)) || $stable(dbg_data_o)));
endmodule

bind alu_exec_core alu_exec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .illegal_o (illegal_o),
  .dbg_addr_i(dbg_addr_i),
  .dbg_data_o(dbg_data_o),
  .wr_en     (wr_en),
  .wr_addr   (dst)
);

// File: tb/alu_exec_core_tb.sv
module alu_exec_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        illegal;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] model [32];

  always #5 clk = ~clk;

  alu_exec_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data), .illegal_o(illegal)
  );

  function automatic logic [31:0] enc_r(input int rs, rt, rd, sh, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rs, rt, input logic [15:0] imm);
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction

  // reference: {legal, dest, value}
  function automatic logic [37:0] ref_exec(input logic [31:0] w);
    logic [31:0] a, b, y, sx, zx;
    logic        ok;
    logic [4:0]  d;
    a  = model[w[25:21]];
    b  = model[w[20:16]];
    sx = 32'($signed(w[15:0]));
    zx = {16'd0, w[15:0]};
    ok = 1'b1; y = '0; d = w[20:16];
    case (w[31:26])
      6'b000000: begin
        d = w[15:11];
        case (w[5:0])
          6'b100000: y = a + b;
          6'b100010: y = a - b;
          6'b000000: y = b << w[10:6];
          6'b000010: y = b >> w[10:6];
          6'b100100: y = a & b;
          6'b100101: y = a | b;
          6'b100110: y = a ^ b;
          6'b100111: y = ~(a | b);
          default:   ok = 1'b0;
        endcase
      end
      6'b001000: y = a + sx;
      6'b001100: y = a & zx;
      6'b001101: y = a | zx;
      6'b001110: y = a ^ zx;
      default:   ok = 1'b0;
    endcase
    return {ok, d, y};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic v, input string tag);
    logic [37:0] r;
    r = ref_exec(w);
    @(negedge clk);
    instr = w; valid = v;
    #1;
    check({tag, "/R9 flag"}, {31'd0, illegal}, {31'd0, v & ~r[37]});
    @(negedge clk);
    valid = 1'b0;
    if (v && r[37] && r[36:32] != 5'd0) model[r[36:32]] = r[31:0];
  endtask

  // R11: value read back one edge after issue
  task automatic check_reg(input int r, input string tag);
    dbg_addr = 5'(r);
    #1;
    check(tag, dbg_data, model[r]);
  endtask

  task automatic load_reg(input int r, input logic [31:0] v);
    issue(enc_i(6'b001101, 0, r, v[31:16]), 1'b1, "R7 load");
    issue(enc_r(0, r, r, 16, 6'b000000), 1'b1, "R4 load");
    issue(enc_i(6'b001101, r, r, v[15:0]), 1'b1, "R7 load");
    check_reg(r, "R11 load");
  endtask

  function automatic bit is_legal_fn(input logic [5:0] f);
    return f inside {6'b000000, 6'b000010, 6'b100000, 6'b100010,
                     6'b100100, 6'b100101, 6'b100110, 6'b100111};
  endfunction

  initial begin
    logic [31:0] pats [8];
    logic [5:0]  rfn [6];
    logic [5:0]  iop [4];
    pats = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
             32'h7FFF_FFFF, 32'h1234_5678, 32'hB800_0009, 32'h0F0F_00F0};
    rfn  = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b100110, 6'b100111};
    iop  = '{6'b001000, 6'b001100, 6'b001101, 6'b001110};
    for (int i = 0; i < 32; i++) model[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // dirty some registers, then reset again (R1)
    for (int i = 1; i < 6; i++) load_reg(i, 32'hA5A5_0000 + 32'(i));
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    #2;
    for (int i = 0; i < 32; i++) check_reg(i, "R1 reset");
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 8; i++) load_reg(i + 1, pats[i]);

    // R2 R3 R5: all register pairs, all three-register ops
    for (int a = 1; a <= 8; a++)
      for (int b = 1; b <= 8; b++)
        for (int k = 0; k < 6; k++) begin
          issue(enc_r(a, b, 20, 0, rfn[k]), 1'b1, "R2/R3/R5");
          check_reg(20, k == 0 ? "R2 add" : k == 1 ? "R3 sub" : "R5 logic");
        end

    // R4: every shift amount, rs field nonzero and irrelevant
    for (int r = 1; r <= 8; r++)
      for (int sh = 0; sh < 32; sh++) begin
        issue(enc_r(5, r, 21, sh, 6'b000000), 1'b1, "R4");
        check_reg(21, "R4 sll");
        issue(enc_r(3, r, 21, sh, 6'b000010), 1'b1, "R4");
        check_reg(21, "R4 srl");
      end
    issue(enc_r(0, 7, 21, 4, 6'b000000), 1'b1, "R4");
    dbg_addr = 5'd21; #1; check("R4 example", dbg_data, 32'h8000_0090);

    // R6 R7: immediates across sign boundary
    for (int r = 1; r <= 8; r++)
      for (int k = 0; k < 64; k++)
        for (int j = 0; j < 4; j++) begin
          logic [15:0] imm;
          imm = (k == 62) ? 16'h7FFF : (k == 63) ? 16'h8000 : 16'((k << 10) | (k * 37));
          issue(enc_i(iop[j], r, 22, imm), 1'b1, "R6/R7");
          check_reg(22, j == 0 ? "R6 addi" : "R7 logic imm");
        end
    issue(enc_i(6'b001000, 0, 22, 16'hFFFF), 1'b1, "R6");
    dbg_addr = 5'd22; #1; check("R6 minus one", dbg_data, 32'hFFFF_FFFF);
    issue(enc_i(6'b001101, 0, 22, 16'hFFFF), 1'b1, "R7");
    dbg_addr = 5'd22; #1; check("R7 zero extend", dbg_data, 32'h0000_FFFF);

    // R8: register zero
    issue(enc_r(3, 3, 0, 0, 6'b100000), 1'b1, "R8");
    check_reg(0, "R8 rtype to r0");
    issue(enc_i(6'b001000, 0, 0, 16'h0005), 1'b1, "R8");
    dbg_addr = 5'd0; #1; check("R8 addi to r0", dbg_data, 32'h0);
    issue(enc_r(0, 6, 23, 0, 6'b100000), 1'b1, "R8");
    dbg_addr = 5'd23; #1; check("R8 r0 source", dbg_data, pats[5]);
    issue(enc_i(6'b001000, 7, 23, 16'h0000), 1'b1, "R8");
    dbg_addr = 5'd23; #1; check("R8 move", dbg_data, pats[6]);

    // R9: every unlisted opcode and function code
    load_reg(24, 32'hCAFE_F00D);
    for (int op = 0; op < 64; op++)
      if (!(6'(op) inside {6'b000000, 6'b001000, 6'b001100, 6'b001101, 6'b001110})) begin
        issue(enc_i(6'(op), 1, 24, 16'h1234), 1'b1, "R9 opcode");
        dbg_addr = 5'd24; #1; check("R9 opcode no write", dbg_data, 32'hCAFE_F00D);
      end
    for (int fn = 0; fn < 64; fn++)
      if (!is_legal_fn(6'(fn))) begin
        issue(enc_r(1, 2, 24, 3, 6'(fn)), 1'b1, "R9 funct");
        dbg_addr = 5'd24; #1; check("R9 funct no write", dbg_data, 32'hCAFE_F00D);
      end

    // R10: valid low
    issue(enc_i(6'b001000, 0, 25, 16'h0007), 1'b0, "R10");
    dbg_addr = 5'd25; #1; check("R10 no write", dbg_data, 32'h0);
    issue(enc_i(6'b111111, 0, 25, 16'h0007), 1'b0, "R10 illegal code");
    dbg_addr = 5'd25; #1; check("R10 still zero", dbg_data, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule